// File: doc/BRIEF.md
# Security-Banked Stack Pointer File

This block keeps the stack pointers of a small microcontroller core that runs in one of two security states, secure and non-secure. Each state owns a main pointer and a process pointer, which makes four pointers in all. The datapath sees only one of them, the active pointer, on `activeSp`. The block holds the other three internally. The active pointer is the process pointer of the current state when the core runs in thread mode and that state's stack-select bit is set. In every other case it is the main pointer of the current state. When the core is built without the security extension, only one state exists and the block keeps two pointers.

The surrounding core drives four things: the handler/thread mode, one stack-select bit per state, a one-cycle request to enter a given security state, and a write port for the active pointer. Each edge the block works out which pointer must be live after that edge and moves the values to match. Every input sampled at a rising edge shows its effect on `activeSp` and `secureNow` directly after that edge. A write issued in the same cycle as a swap goes into the pointer that was live before the swap.

Top module: `banked_sp_file`

## Requirements
- R1: While reset is asserted and directly after it is released, `activeSp` is 0 and `secureNow` is 1, where 1 means secure and 0 means non-secure. All four pointers read as 0 when first selected.
- R2: With `spWrEn` high and no change of state or of live role at that edge, `activeSp` equals `spWrData` after the edge.
- R3: In thread mode (`handlerMode` 0), the process pointer of the current state is live when that state's stack-select bit is set. The stack-select bit of the other state has no effect on `activeSp`.
- R4: In handler mode (`handlerMode` 1), the main pointer of the current state is live even if that state's stack-select bit is set.
- R5: When `secReq` is high and `secTarget` differs from `secureNow`, `secureNow` takes `secTarget` at that edge. `activeSp` then shows the target state's main or process pointer, chosen by the mode and the target state's stack-select bit.
- R6: When `secReq` is high and `secTarget` equals `secureNow`, neither `secureNow` nor `activeSp` changes.
- R7: A pointer keeps its value while its state is inactive. Returning to that state shows the stored value again in the same role.
- R8: A write in the same cycle as a security switch lands in the pointer that was live before the switch.
- R9: A change of stack-select within one state swaps the live pointer with its same-state partner. The pointers of the inactive state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| handlerMode | input | 1 | 1 = handler mode, 0 = thread mode |
| spSelSec | input | 1 | Stack-select bit of the secure state |
| spSelNs | input | 1 | Stack-select bit of the non-secure state |
| secReq | input | 1 | Request to enter the state given by secTarget |
| secTarget | input | 1 | Requested state, 1 = secure |
| spWrEn | input | 1 | Write enable for the active pointer |
| spWrData | input | SP_W | Value written to the active pointer |
| activeSp | output | SP_W | Currently live stack pointer |
| secureNow | output | 1 | Current security state, 1 = secure |

## Verification
All results of this block appear one cycle after their stimulus: inputs presented before a rising edge show on `activeSp` and `secureNow` directly after that edge. The driver applies inputs on the falling edge and queues the value the pointer model predicts for the next edge. The monitor pops that item one time unit after the rising edge and compares it, so every check samples the registered outputs exactly one edge after its stimulus. Values hidden in a shadow register are checked indirectly: a later switch or mode change brings them back to `activeSp`.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic wrLive;   // write port hits the live pointer
    logic selSwap;  // swap live and same-state partner
    logic secSwap;  // exchange banks on a security switch
    logic oldPsp;   // live pointer before the edge is a process pointer
    logic newPsp;   // live pointer after a switch is a process pointer
  } spStrobe_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      handlerMode,
  input  logic      spSelSec,
  input  logic      spSelNs,
  input  logic      secReq,
  input  logic      secTarget,
  input  logic      spWrEn,
  output spStrobe_t strobe,
  output logic      secureNow
);
  localparam logic RST_SEC = HAS_SEC;

  logic secureQ;
  logic liveIsPsp;
  logic selCur;
  logic selOther;
  logic wantCur;
  logic wantNew;
  logic doSec;

  assign selCur   = secureQ ? spSelSec : spSelNs;
  assign selOther = secureQ ? spSelNs  : spSelSec;
  assign wantCur  = !handlerMode && selCur;
  assign wantNew  = !handlerMode && selOther;

  generate
    if (HAS_SEC) begin : gSec
      assign doSec = secReq && (secTarget != secureQ);
    end else begin : gNoSec
      assign doSec = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe.wrLive  = spWrEn;
    strobe.secSwap = doSec;
    strobe.selSwap = !doSec && (wantCur != liveIsPsp);
    strobe.oldPsp  = liveIsPsp;
    strobe.newPsp  = wantNew;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secureQ   <= RST_SEC;
      liveIsPsp <= 1'b0;
    end else if (doSec) begin
      secureQ   <= !secureQ;
      liveIsPsp <= wantNew;
    end else begin
      liveIsPsp <= wantCur;
    end
  end

  assign secureNow = secureQ;
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int SP_W    = 32,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  spStrobe_t       strobe,
  input  logic [SP_W-1:0] wrData,
  output logic [SP_W-1:0] liveSp,
  output logic [SP_W-1:0] otherSp
);
  logic [SP_W-1:0] liveQ;
  logic [SP_W-1:0] otherQ;
  logic [SP_W-1:0] bankMsp;
  logic [SP_W-1:0] bankPsp;
  logic [SP_W-1:0] liveNext;

  assign liveNext = strobe.wrLive ? wrData : liveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ  <= '0;
      otherQ <= '0;
    end else if (strobe.secSwap) begin
      liveQ  <= strobe.newPsp ? bankPsp : bankMsp;
      otherQ <= strobe.newPsp ? bankMsp : bankPsp;
    end else if (strobe.selSwap) begin
      liveQ  <= otherQ;
      otherQ <= liveNext;
    end else begin
      liveQ  <= liveNext;
    end
  end

  generate
    if (HAS_SEC) begin : gBank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankMsp <= '0;
          bankPsp <= '0;
        end else if (strobe.secSwap) begin
          bankMsp <= strobe.oldPsp ? otherQ : liveNext;
          bankPsp <= strobe.oldPsp ? liveNext : otherQ;
        end
      end
    end else begin : gNoBank
      assign bankMsp = '0;
      assign bankPsp = '0;
    end
  endgenerate

  assign liveSp  = liveQ;
  assign otherSp = otherQ;
endmodule

// File: rtl/banked_sp_file.sv
module banked_sp_file
  import sp_pkg::*;
#(
  parameter int SP_W    = 32,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            handlerMode,
  input  logic            spSelSec,
  input  logic            spSelNs,
  input  logic            secReq,
  input  logic            secTarget,
  input  logic            spWrEn,
  input  logic [SP_W-1:0] spWrData,
  output logic [SP_W-1:0] activeSp,
  output logic            secureNow
);
  spStrobe_t       strobe;
  logic [SP_W-1:0] otherSp;

  sp_ctrl #(.HAS_SEC(HAS_SEC)) uCtrl (
    .clk(clk), .rstN(rstN), .handlerMode(handlerMode),
    .spSelSec(spSelSec), .spSelNs(spSelNs), .secReq(secReq),
    .secTarget(secTarget), .spWrEn(spWrEn), .strobe(strobe),
    .secureNow(secureNow)
  );

  sp_datapath #(.SP_W(SP_W), .HAS_SEC(HAS_SEC)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(spWrData),
    .liveSp(activeSp), .otherSp(otherSp)
  );
endmodule

// File: rtl/banked_sp_file_chk.sv
module banked_sp_file_chk
  import sp_pkg::*;
#(
  parameter int SP_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            secReq,
  input logic            secTarget,
  input logic            spWrEn,
  input logic [SP_W-1:0] spWrData,
  input logic [SP_W-1:0] activeSp,
  input logic [SP_W-1:0] otherSp,
  input logic            secureNow,
  input spStrobe_t       strobe
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn && !strobe.secSwap && !strobe.selSwap |=> activeSp == $past(spWrData));

  a_r5_state_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.secSwap |=> secureNow != $past(secureNow));

  a_r6_same_state_idle: assert property (@(posedge clk) disable iff (!rstN)
    secReq && (secTarget == secureNow) && !spWrEn && !strobe.selSwap
      |=> $stable(secureNow) && $stable(activeSp));

  a_r9_partner_swap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selSwap |=> activeSp == $past(otherSp));

  a_r6_no_request_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    !secReq |=> $stable(secureNow));
endmodule

bind banked_sp_file banked_sp_file_chk #(.SP_W(SP_W)) uChk (
  .clk(clk), .rstN(rstN), .secReq(secReq), .secTarget(secTarget),
  .spWrEn(spWrEn), .spWrData(spWrData), .activeSp(activeSp),
  .otherSp(otherSp), .secureNow(secureNow), .strobe(strobe)
);

// File: tb/tb_banked_sp_file.sv
module tb_banked_sp_file;
  localparam int SP_W = 32;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic handlerMode = 1'b0, spSelSec = 1'b0, spSelNs = 1'b0;
  logic secReq = 1'b0, secTarget = 1'b0, spWrEn = 1'b0;
  logic [SP_W-1:0] spWrData = '0;
  logic [SP_W-1:0] activeSp;
  logic secureNow;

  int nCmp = 0, nBad = 0;
  bit finished = 1'b0;

  // pointer model: [state 1=secure][role 1=process]
  logic [SP_W-1:0] mSp [2][2];
  logic mSec, mRole;

  logic [SP_W-1:0] qSp[$];
  logic qSec[$];
  string qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_sp_file #(.SP_W(SP_W), .HAS_SEC(1'b1)) dut (
    .clk(clk), .rstN(rstN), .handlerMode(handlerMode),
    .spSelSec(spSelSec), .spSelNs(spSelNs), .secReq(secReq),
    .secTarget(secTarget), .spWrEn(spWrEn), .spWrData(spWrData),
    .activeSp(activeSp), .secureNow(secureNow)
  );

  task automatic compare(input logic [SP_W-1:0] expSp, input logic expSec, input string tag);
    nCmp++;
    if (activeSp !== expSp || secureNow !== expSec) begin
      nBad++;
      $display("FAIL %s: activeSp=%h secureNow=%b, expected %h %b",
               tag, activeSp, secureNow, expSp, expSec);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the prediction
  task automatic step(input logic hm, input logic sS, input logic sN,
                      input logic rq, input logic tg, input logic we,
                      input logic [SP_W-1:0] wd, input string tag);
    @(negedge clk);
    handlerMode = hm; spSelSec = sS; spSelNs = sN;
    secReq = rq; secTarget = tg; spWrEn = we; spWrData = wd;
    if (we) mSp[mSec][mRole] = wd;
    if (rq) mSec = tg;
    mRole = !hm && (mSec ? sS : sN);
    qSp.push_back(mSp[mSec][mRole]);
    qSec.push_back(mSec);
    qTag.push_back(tag);
  endtask

  // monitor: compares one time unit after each rising edge
  always @(posedge clk) begin
    if (qSp.size() > 0) begin
      #1;
      compare(qSp.pop_front(), qSec.pop_front(), qTag.pop_front());
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++) mSp[s][r] = '0;
    mSec = 1'b1; mRole = 1'b0;
    repeat (3) @(negedge clk);
    compare('0, 1'b1, "R1 during reset");
    rstN = 1'b1;
    @(posedge clk); #1;
    compare('0, 1'b1, "R1 after reset");

    step(0, 0, 0, 0, 0, 1, 32'h0000_0100, "R2 write secure main");
    step(0, 1, 0, 0, 0, 0, '0,            "R3 select secure process");
    step(0, 1, 0, 0, 0, 1, 32'h0000_0200, "R2 write secure process");
    step(0, 1, 1, 0, 0, 0, '0,            "R3 other-state select ignored");
    step(1, 1, 1, 0, 0, 0, '0,            "R4 handler uses main");
    step(0, 1, 1, 0, 0, 0, '0,            "R3 back to process");
    step(0, 1, 1, 1, 1, 0, '0,            "R6 same-state request");
    step(0, 1, 0, 1, 0, 0, '0,            "R5 switch to non-secure main");
    step(0, 1, 0, 0, 0, 1, 32'h0000_0300, "R2 write non-secure main");
    step(0, 1, 1, 0, 0, 0, '0,            "R9 select non-secure process");
    step(0, 1, 1, 0, 0, 1, 32'h0000_0400, "R2 write non-secure process");
    step(0, 1, 0, 0, 0, 0, '0,            "R9 back to non-secure main");
    step(0, 1, 0, 1, 1, 0, '0,            "R7 return to secure process");
    step(1, 1, 0, 0, 0, 0, '0,            "R7 secure main kept");
    step(1, 1, 0, 1, 0, 1, 32'h0000_0AAA, "R8 write with switch");
    step(0, 1, 1, 0, 0, 0, '0,            "R7 non-secure process kept");
    step(1, 1, 1, 1, 1, 0, '0,            "R8 written value saved");
    step(0, 1, 1, 0, 0, 0, '0,            "R9 secure process untouched");
    step(0, 1, 1, 0, 0, 0, '0,            "R6 idle cycle");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      finished = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule